// File: doc/BRIEF.md
# Paged memory map decoder

This block turns a 16-bit processor address and a memory request into chip selects for a ROM array and a DRAM array. A write-only page register sets which parts of memory are visible. That register holds a mode bit, a 3-bit ROM page and a 4-bit RAM page. The mode bit selects one of two memory maps.

In ROM mode, the bottom 16K holds ROM. The lower 8K of that is a fixed monitor ROM. The upper 8K is one of eight paged ROMs. The 32K from 4000h to BFFFh is a window into the selected RAM page. In RAM mode, no ROM is visible, and the whole 48K below C000h is a window into the selected RAM page. In both modes the top 16K is a RAM block that every page shares.

For a RAM access, the block gives the DRAM controller a 16K bank index. That index is the high part of the DRAM address. Only low page numbers map to physical banks, so higher page numbers select nothing. This is why only part of the nominal RAM can be reached.

Top module: `mmap_decoder`

## Requirements
- R1: The active-low asynchronous reset clears the page register to 00h. After reset the block is in ROM mode, with ROM page 0 and RAM page 0.
- R2: In ROM mode, a request to 0000h–1FFFh asserts rom_sel_o and holds rom_paged_o at 0 (monitor ROM).
- R3: In ROM mode, a request to 2000h–3FFFh asserts rom_sel_o and rom_paged_o. rom_page_o equals page register bits [6:4].
- R4: In ROM mode, a request to 4000h–BFFFh with RAM page p (page register bits [3:0]) below 2 asserts ram_sel_o. The bank is 2*p + A[15:14], so it lies in 1..4. For p of 2 or more, nothing is selected.
- R5: Page register bit 7 set selects RAM mode, and then rom_sel_o is never asserted. A request to 0000h–BFFFh with p below 4 asserts ram_sel_o. The bank is 3*p + A[15:14] + 1, so it lies in 1..12. For p of 4 or more, nothing is selected.
- R6: A request to C000h–FFFFh asserts ram_sel_o with bank 0 in both modes, for every page value.
- R7: With mreq_i low, all outputs are 0. Whenever a select is not asserted, the outputs tied to it (rom_page_o, ram_bank_o) are 0.
- R8: A page write takes effect at the clock edge that samples page_we_i. An access in the same cycle as the write is decoded with the old page value.
- R9: rom_sel_o and ram_sel_o are never both asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 16 | Processor address |
| mreq_i | input | 1 | Memory request, active high |
| page_we_i | input | 1 | Page register write strobe |
| page_wdata_i | input | 8 | Page value: [7] RAM mode, [6:4] ROM page, [3:0] RAM page |
| rom_sel_o | output | 1 | ROM chip select |
| rom_paged_o | output | 1 | Paged ROM selected (0 = monitor ROM) |
| rom_page_o | output | 3 | Selected paged ROM |
| ram_sel_o | output | 1 | DRAM select |
| ram_bank_o | output | 4 | 16K DRAM bank index |

## Verification
A page write and a memory access can fall in the same cycle. The decode must then use the register value from before the write, and the new value only after the edge. The bench provokes this in two ways. First, it raises page_we_i while a request to address 0000h is active, changing from ROM mode to RAM mode. Second, it raises page_we_i while a request is active in the paged window, changing the RAM page. It samples the selects just before and just after the loading edge. It expects a ROM select followed by bank 1 in the first case, and two different banks in the second case.

// File: rtl/mmap_pkg.sv
package mmap_pkg;
  localparam int ROM_PG_W = 3;
  localparam int RAM_PG_W = 4;
  localparam int PAGE_W   = 1 + ROM_PG_W + RAM_PG_W;

  typedef struct packed {
    logic                ram_map;
    logic [ROM_PG_W-1:0] rom_pg;
    logic [RAM_PG_W-1:0] ram_pg;
  } page_t;

  typedef enum logic [1:0] {
    REG_LOW    = 2'd0,
    REG_MID    = 2'd1,
    REG_HIGH   = 2'd2,
    REG_COMMON = 2'd3
  } region_e;

  function automatic region_e region_of(input logic [15:0] a);
    return region_e'(a[15:14]);
  endfunction
endpackage

// File: rtl/mmap_page_reg.sv
module mmap_page_reg
  import mmap_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [PAGE_W-1:0] wdata_i,
  output page_t             page_o
);
  page_t page_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   page_q <= '0;
    else if (we_i) page_q <= page_t'(wdata_i);
  end

  assign page_o = page_q;
endmodule

// File: rtl/mmap_rom_dec.sv
module mmap_rom_dec
  import mmap_pkg::*;
(
  input  page_t               page_i,
  input  logic [15:0]         addr_i,
  input  logic                mreq_i,
  output logic                rom_sel_o,
  output logic                rom_paged_o,
  output logic [ROM_PG_W-1:0] rom_page_o
);
  logic in_rom;

  always_comb begin
    in_rom      = mreq_i && !page_i.ram_map && (region_of(addr_i) == REG_LOW);
    rom_sel_o   = in_rom;
    // bit 13 splits the fixed monitor from the paged slot
    rom_paged_o = in_rom && addr_i[13];
    rom_page_o  = rom_paged_o ? page_i.rom_pg : '0;
  end
endmodule

// File: rtl/mmap_ram_dec.sv
module mmap_ram_dec
  import mmap_pkg::*;
#(
  parameter int ROM_LIVE_PAGES = 2,
  parameter int RAM_LIVE_PAGES = 4,
  parameter int BANK_W         = 4
) (
  input  page_t              page_i,
  input  logic [15:0]        addr_i,
  input  logic               mreq_i,
  output logic               ram_sel_o,
  output logic [BANK_W-1:0]  ram_bank_o
);
  localparam int ROM_WIN = 2;  // 16K slots in the ROM-mode window
  localparam int RAM_WIN = 3;  // 16K slots in the RAM-mode window

  region_e rgn;
  int      pg;
  int      bank;
  logic    hit;

  always_comb begin
    rgn  = region_of(addr_i);
    pg   = int'(page_i.ram_pg);
    hit  = 1'b0;
    bank = 0;
    if (rgn == REG_COMMON) begin
      hit  = 1'b1;
      bank = 0;
    end else if (page_i.ram_map) begin
      hit  = pg < RAM_LIVE_PAGES;
      bank = RAM_WIN * pg + int'(rgn) + 1;
    end else if (rgn != REG_LOW) begin
      hit  = pg < ROM_LIVE_PAGES;
      bank = ROM_WIN * pg + int'(rgn);
    end
    ram_sel_o  = mreq_i && hit;
    ram_bank_o = ram_sel_o ? BANK_W'(bank) : '0;
  end
endmodule

// File: rtl/mmap_decoder.sv
module mmap_decoder
  import mmap_pkg::*;
#(
  parameter int ROM_LIVE_PAGES = 2,
  parameter int RAM_LIVE_PAGES = 4,
  parameter int BANK_W         = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [15:0]       addr_i,
  input  logic              mreq_i,
  input  logic              page_we_i,
  input  logic [7:0]        page_wdata_i,
  output logic              rom_sel_o,
  output logic              rom_paged_o,
  output logic [2:0]        rom_page_o,
  output logic              ram_sel_o,
  output logic [BANK_W-1:0] ram_bank_o
);
  page_t page;

  mmap_page_reg u_page (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (page_we_i),
    .wdata_i (page_wdata_i),
    .page_o  (page)
  );

  mmap_rom_dec u_rom (
    .page_i      (page),
    .addr_i      (addr_i),
    .mreq_i      (mreq_i),
    .rom_sel_o   (rom_sel_o),
    .rom_paged_o (rom_paged_o),
    .rom_page_o  (rom_page_o)
  );

  mmap_ram_dec #(
    .ROM_LIVE_PAGES (ROM_LIVE_PAGES),
    .RAM_LIVE_PAGES (RAM_LIVE_PAGES),
    .BANK_W         (BANK_W)
  ) u_ram (
    .page_i     (page),
    .addr_i     (addr_i),
    .mreq_i     (mreq_i),
    .ram_sel_o  (ram_sel_o),
    .ram_bank_o (ram_bank_o)
  );
endmodule

// File: rtl/mmap_decoder_chk.sv
module mmap_decoder_chk #(
  parameter int BANK_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [15:0]       addr_i,
  input logic              mreq_i,
  input logic              page_we_i,
  input logic [7:0]        page_wdata_i,
  input logic              rom_sel_o,
  input logic              rom_paged_o,
  input logic [2:0]        rom_page_o,
  input logic              ram_sel_o,
  input logic [BANK_W-1:0] ram_bank_o
);
  logic mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        mode_q <= 1'b0;
    else if (page_we_i) mode_q <= page_wdata_i[7];
  end

  AST_SEL_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rom_sel_o && ram_sel_o)); // R9

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mreq_i |-> (!rom_sel_o && !ram_sel_o && ram_bank_o == '0 && rom_page_o == '0)); // R7

  AST_COMMON_BANK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mreq_i && addr_i[15:14] == 2'b11) |-> (ram_sel_o && ram_bank_o == '0)); // R6

  AST_RAM_MODE_NO_ROM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_q |-> !rom_sel_o); // R5

  AST_MONITOR_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_q && mreq_i && addr_i[15:13] == 3'b000) |-> (rom_sel_o && !rom_paged_o)); // R2

  AST_PAGED_SLOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_q && mreq_i && addr_i[15:13] == 3'b001) |-> (rom_sel_o && rom_paged_o)); // R3

  AST_ROM_PAGE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rom_paged_o |-> rom_page_o == '0); // R7
endmodule

bind mmap_decoder mmap_decoder_chk #(.BANK_W(BANK_W)) u_chk (.*);

// File: tb/sim_mmap_decoder.sv
module sim_mmap_decoder;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] addr_i = '0;
  logic        mreq_i = 1'b0;
  logic        page_we_i = 1'b0;
  logic [7:0]  page_wdata_i = '0;
  logic        rom_sel_o, rom_paged_o, ram_sel_o;
  logic [2:0]  rom_page_o;
  logic [3:0]  ram_bank_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  mmap_decoder u0 (.*);

  // {page, addr, rom_sel, rom_paged, rom_page, ram_sel, bank}
  localparam int NV = 14;
  localparam logic [33:0] VEC [NV] = '{
    {8'h00, 16'h0000, 1'b1, 1'b0, 3'd0, 1'b0, 4'd0},
    {8'h00, 16'h1FFF, 1'b1, 1'b0, 3'd0, 1'b0, 4'd0},
    {8'h50, 16'h2000, 1'b1, 1'b1, 3'd5, 1'b0, 4'd0},
    {8'h70, 16'h3FFF, 1'b1, 1'b1, 3'd7, 1'b0, 4'd0},
    {8'h00, 16'h4000, 1'b0, 1'b0, 3'd0, 1'b1, 4'd1},
    {8'h01, 16'h8000, 1'b0, 1'b0, 3'd0, 1'b1, 4'd4},
    {8'h01, 16'h4000, 1'b0, 1'b0, 3'd0, 1'b1, 4'd3},
    {8'h02, 16'h4000, 1'b0, 1'b0, 3'd0, 1'b0, 4'd0},
    {8'h0F, 16'hC000, 1'b0, 1'b0, 3'd0, 1'b1, 4'd0},
    {8'h80, 16'h0000, 1'b0, 1'b0, 3'd0, 1'b1, 4'd1},
    {8'h83, 16'hBFFF, 1'b0, 1'b0, 3'd0, 1'b1, 4'd12},
    {8'h84, 16'h4000, 1'b0, 1'b0, 3'd0, 1'b0, 4'd0},
    {8'h8F, 16'hFFFF, 1'b0, 1'b0, 3'd0, 1'b1, 4'd0},
    {8'hF0, 16'h2000, 1'b0, 1'b0, 3'd0, 1'b1, 4'd1}
  };

  function automatic logic [9:0] outs();
    return {rom_sel_o, rom_paged_o, rom_page_o, ram_sel_o, ram_bank_o};
  endfunction

  // Expected outputs computed from the requirements.
  function automatic logic [9:0] ref_map(input logic [7:0] pg, input logic [15:0] a, input logic rq);
    int p;
    int s;
    logic [9:0] r;
    p = int'(pg[3:0]);
    s = int'(a[15:14]);
    r = '0;
    if (!rq) return r;
    if (s == 3) r = {1'b0, 1'b0, 3'd0, 1'b1, 4'd0};
    else if (pg[7]) begin
      if (p < 4) r = {1'b0, 1'b0, 3'd0, 1'b1, 4'(3 * p + s + 1)};
    end else if (s == 0) begin
      if (a[13]) r = {1'b1, 1'b1, pg[6:4], 1'b0, 4'd0};
      else       r = {1'b1, 1'b0, 3'd0, 1'b0, 4'd0};
    end else if (p < 2) r = {1'b0, 1'b0, 3'd0, 1'b1, 4'(2 * p + s)};
    return r;
  endfunction

  function automatic string tag_of(input logic [7:0] pg, input logic [15:0] a);
    if (a[15:14] == 2'b11) return "R6";
    if (pg[7])             return "R5";
    if (a[15:14] != 2'b00) return "R4";
    return a[13] ? "R3" : "R2";
  endfunction

  task automatic check(input string req, input logic [9:0] act, input logic [9:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic write_page(input logic [7:0] v);
    @(negedge clk_i);
    page_we_i = 1'b1;
    page_wdata_i = v;
    @(negedge clk_i);
    page_we_i = 1'b0;
  endtask

  task automatic access(input logic [15:0] a, input logic rq);
    addr_i = a;
    mreq_i = rq;
    #1;
  endtask

  localparam logic [15:0] PTS [10] = '{16'h0000, 16'h1FFF, 16'h2000, 16'h3FFF, 16'h4000,
                                      16'h7FFF, 16'h8000, 16'hBFFF, 16'hC000, 16'hFFFF};

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1: reset state is ROM mode, page 0
    access(16'h2000, 1'b1);
    check("R1", outs(), {1'b1, 1'b1, 3'd0, 1'b0, 4'd0});
    access(16'h4000, 1'b1);
    check("R1", outs(), {1'b0, 1'b0, 3'd0, 1'b1, 4'd1});

    for (int i = 0; i < NV; i++) begin
      write_page(VEC[i][33:26]);
      access(VEC[i][25:10], 1'b1);
      check(tag_of(VEC[i][33:26], VEC[i][25:10]), outs(), VEC[i][9:0]);
    end

    // full sweep of modes, pages and regions
    for (int m = 0; m < 2; m++)
      for (int r = 0; r < 8; r += 3)
        for (int p = 0; p < 16; p++) begin
          logic [7:0] pg;
          pg = {1'(m), 3'(r), 4'(p)};
          write_page(pg);
          for (int k = 0; k < 10; k++) begin
            access(PTS[k], 1'b1);
            check(tag_of(pg, PTS[k]), outs(), ref_map(pg, PTS[k], 1'b1));
          end
        end

    // R7: no request means no select
    write_page(8'h00);
    access(16'h0000, 1'b0);
    check("R7", outs(), 10'd0);
    write_page(8'h80);
    access(16'hC000, 1'b0);
    check("R7", outs(), 10'd0);
    access(16'h4000, 1'b0);
    check("R7", outs(), 10'd0);

    // R8: write in same cycle as access, ROM mode to RAM mode
    write_page(8'h00);
    @(negedge clk_i);
    page_we_i = 1'b1;
    page_wdata_i = 8'h80;
    access(16'h0000, 1'b1);
    check("R8", outs(), {1'b1, 1'b0, 3'd0, 1'b0, 4'd0});
    @(posedge clk_i);
    #1;
    check("R8", outs(), {1'b0, 1'b0, 3'd0, 1'b1, 4'd1});
    @(negedge clk_i);
    page_we_i = 1'b0;

    // R8: page change while RAM window access active
    @(negedge clk_i);
    page_we_i = 1'b1;
    page_wdata_i = 8'h82;
    access(16'h8000, 1'b1);
    check("R8", outs(), {1'b0, 1'b0, 3'd0, 1'b1, 4'd3});
    @(posedge clk_i);
    #1;
    check("R8", outs(), {1'b0, 1'b0, 3'd0, 1'b1, 4'd9});
    @(negedge clk_i);
    page_we_i = 1'b0;

    // R9: exclusivity across a whole ROM-mode sweep
    write_page(8'h31);
    for (int k = 0; k < 10; k++) begin
      access(PTS[k], 1'b1);
      check("R9", {9'd0, rom_sel_o && ram_sel_o}, 10'd0);
    end

    // R1: reset in mid-run clears an all-ones page
    write_page(8'hFF);
    access(16'h2000, 1'b1);
    check("R5", outs(), 10'd0);
    rst_ni = 1'b0;
    #2;
    rst_ni = 1'b1;
    #1;
    check("R1", outs(), {1'b1, 1'b1, 3'd0, 1'b0, 4'd0});

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule